// File: doc/BRIEF.md
# Unaligned Load/Store Merge Unit

This block sits between the load/store stage of a 32-bit pipeline and a word-organised data memory. Every request carries an operation code, a byte address, the store data and the current value of the destination register. The block decides in the request cycle whether the access may go to memory. An ordinary halfword or word access to an address that is not a multiple of its size is turned into an alignment fault, and the address is reported so a handler can emulate the access. Otherwise the block issues one word-aligned memory access with a per-lane byte enable.

Four paired instructions move data across a word boundary without faulting. A left load merges the tail of the lower memory word into the top of the register. A right load merges the head of the upper memory word into the bottom. Left and right stores write only the lanes that belong to their word. Byte order is big-endian. Memory read data arrives one cycle after the request, and the merged or extended load result is presented in that cycle.

Top module: `lsu_merge_unit`

## Requirements
- R1: A halfword request (codes 2, 3, 6) with address bit 0 set, or a word request (codes 4, 7) with address bits [1:0] nonzero, raises faultValid in the request cycle with faultAddr equal to reqAddr.
- R2: Byte requests (codes 0, 1, 5) and the paired unaligned requests (codes 8, 9, 10, 11) never raise faultValid, whatever the address.
- R3: Every memory access uses memAddr = reqAddr with bits [1:0] cleared; memByteEn[j] qualifies memWdata/memRdata bits [8j+7:8j], and the byte at offset k of the word (k = reqAddr[1:0], big-endian) sits in lane 3-k.
- R4: Ordinary loads (0 signed byte, 1 unsigned byte, 2 signed halfword, 3 unsigned halfword, 4 word) assert rspValid one cycle after the request, with the addressed bytes right-justified and sign- or zero-extended in rspData; their byte enables cover the bytes read.
- R5: Left load (code 8) with offset k: rspData = memory bytes k..3 in its top 4-k bytes, the low k bytes taken from reqRegOld; byte enables cover offsets k..3.
- R6: Right load (code 9) with offset k: rspData = memory bytes 0..k in its low k+1 bytes, the upper 3-k bytes taken from reqRegOld; byte enables cover offsets 0..k.
- R7: Ordinary stores (5 byte, 6 halfword, 7 word) enable only the addressed lanes and place the low byte, low halfword or whole word of reqStoreData in them.
- R8: Left store (code 10) with offset k writes memory bytes k..3 with the most significant 4-k bytes of reqStoreData, leaving bytes 0..k-1 of the word unchanged.
- R9: Right store (code 11) with offset k writes memory bytes 0..k with the least significant k+1 bytes of reqStoreData, leaving bytes k+1..3 unchanged.
- R10: A faulting request or an unused code (12 to 15) makes no memory access, leaves memory unchanged and produces no rspValid; disabled write lanes carry zero.
- R11: During and right after reset, memValid, faultValid and rspValid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqOp | input | 4 | Operation code |
| reqAddr | input | ADDR_W | Byte address |
| reqStoreData | input | 32 | Register value to store |
| reqRegOld | input | 32 | Current destination register value for merging loads |
| memRdata | input | 32 | Memory read word, one cycle after a read |
| memValid | output | 1 | Memory access this cycle |
| memWrite | output | 1 | Access is a write |
| memAddr | output | ADDR_W | Word-aligned memory address |
| memByteEn | output | 4 | Per-lane byte enables |
| memWdata | output | 32 | Lane-positioned write data |
| faultValid | output | 1 | Alignment fault for the current request |
| faultAddr | output | ADDR_W | Address of the faulting request |
| rspValid | output | 1 | Load result valid |
| rspData | output | 32 | Extended or merged load result |

## Verification
The bench sweeps every operation code over all four byte offsets of several words, so an off-by-one in the merge boundary of the left or right load shows up as one register byte taken from the wrong source at a single offset, and a reversed lane order shows up as mirrored enables. Stores are followed by a word read compared against a shadow image, which catches a store that touches a neighbouring byte or a faulting store that still writes. Sign extension is exercised with bytes whose top bit is set, and misaligned halfwords at offsets 1 and 3 as well as words at offsets 1 to 3 check that the fault never lets the access through or returns a response.

// File: rtl/lsu_merge_pkg.sv
package lsu_merge_pkg;

  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;
  localparam int LANES  = WORD_W / BYTE_W;

  localparam logic [3:0] OP_LDB  = 4'd0;
  localparam logic [3:0] OP_LDBU = 4'd1;
  localparam logic [3:0] OP_LDH  = 4'd2;
  localparam logic [3:0] OP_LDHU = 4'd3;
  localparam logic [3:0] OP_LDW  = 4'd4;
  localparam logic [3:0] OP_STB  = 4'd5;
  localparam logic [3:0] OP_STH  = 4'd6;
  localparam logic [3:0] OP_STW  = 4'd7;
  localparam logic [3:0] OP_LDL  = 4'd8;
  localparam logic [3:0] OP_LDR  = 4'd9;
  localparam logic [3:0] OP_STL  = 4'd10;
  localparam logic [3:0] OP_STR  = 4'd11;

  typedef enum logic [1:0] {SZ_BYTE, SZ_HALF, SZ_WORD} accSize_e;
  typedef enum logic [1:0] {AK_PLAIN, AK_LEFT, AK_RIGHT} accKind_e;

  typedef struct packed {
    logic     access;
    logic     write;
    accSize_e size;
    accKind_e kind;
    logic     signExt;
  } lsuStrobe_t;

  // Byte b of a word, b = 0 is the most significant (big-endian offset 0).
  function automatic logic [BYTE_W-1:0] getByte(input logic [WORD_W-1:0] w, input int b);
    return w[BYTE_W*(LANES-1-b) +: BYTE_W];
  endfunction

endpackage

// File: rtl/lsu_merge_ctrl.sv
module lsu_merge_ctrl
  import lsu_merge_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              reqValid,
  input  logic [3:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  output lsuStrobe_t        strobe,
  output logic              faultValid,
  output logic [ADDR_W-1:0] faultAddr
);

  lsuStrobe_t decoded;
  logic       known;
  logic       misaligned;

  always_comb begin
    decoded = '0;
    known   = 1'b1;
    decoded.access = 1'b1;
    unique case (reqOp)
      OP_LDB:  begin decoded.size = SZ_BYTE; decoded.signExt = 1'b1; end
      OP_LDBU: begin decoded.size = SZ_BYTE; end
      OP_LDH:  begin decoded.size = SZ_HALF; decoded.signExt = 1'b1; end
      OP_LDHU: begin decoded.size = SZ_HALF; end
      OP_LDW:  begin decoded.size = SZ_WORD; end
      OP_STB:  begin decoded.size = SZ_BYTE; decoded.write = 1'b1; end
      OP_STH:  begin decoded.size = SZ_HALF; decoded.write = 1'b1; end
      OP_STW:  begin decoded.size = SZ_WORD; decoded.write = 1'b1; end
      OP_LDL:  begin decoded.size = SZ_WORD; decoded.kind = AK_LEFT; end
      OP_LDR:  begin decoded.size = SZ_WORD; decoded.kind = AK_RIGHT; end
      OP_STL:  begin decoded.size = SZ_WORD; decoded.kind = AK_LEFT;  decoded.write = 1'b1; end
      OP_STR:  begin decoded.size = SZ_WORD; decoded.kind = AK_RIGHT; decoded.write = 1'b1; end
      default: begin decoded = '0; known = 1'b0; end
    endcase
  end

  always_comb begin
    misaligned = 1'b0;
    if (decoded.kind == AK_PLAIN) begin
      unique case (decoded.size)
        SZ_HALF: misaligned = reqAddr[0];
        SZ_WORD: misaligned = |reqAddr[1:0];
        default: misaligned = 1'b0;
      endcase
    end
  end

  assign faultValid = reqValid && known && misaligned;
  assign faultAddr  = reqAddr;
  assign strobe     = (reqValid && known && !misaligned) ? decoded : '0;

endmodule

// File: rtl/lsu_merge_dp.sv
module lsu_merge_dp
  import lsu_merge_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  lsuStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WORD_W-1:0] reqStoreData,
  input  logic [WORD_W-1:0] reqRegOld,
  input  logic [WORD_W-1:0] memRdata,
  output logic              memValid,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  memByteEn,
  output logic [WORD_W-1:0] memWdata,
  output logic              rspValid,
  output logic [WORD_W-1:0] rspData
);

  localparam int OFF_W = $clog2(LANES);

  logic [LANES-1:0]  laneHit;
  logic [WORD_W-1:0] laneData;

  // Request side: lane selection and write data placement.
  always_comb begin
    int offI;
    logic [BYTE_W-1:0] srcByte;
    offI     = int'(reqAddr[OFF_W-1:0]);
    laneHit  = '0;
    laneData = '0;
    for (int b = 0; b < LANES; b++) begin
      logic hit;
      hit     = 1'b0;
      srcByte = '0;
      unique case (strobe.kind)
        AK_LEFT: if (b >= offI) begin
          hit = 1'b1; srcByte = getByte(reqStoreData, b - offI);
        end
        AK_RIGHT: if (b <= offI) begin
          hit = 1'b1; srcByte = getByte(reqStoreData, b + LANES - 1 - offI);
        end
        default: begin
          unique case (strobe.size)
            SZ_BYTE: if (b == offI) begin
              hit = 1'b1; srcByte = reqStoreData[BYTE_W-1:0];
            end
            SZ_HALF: begin
              if (b == offI) begin
                hit = 1'b1; srcByte = reqStoreData[2*BYTE_W-1:BYTE_W];
              end else if (b == offI + 1) begin
                hit = 1'b1; srcByte = reqStoreData[BYTE_W-1:0];
              end
            end
            default: begin
              hit = 1'b1; srcByte = getByte(reqStoreData, b);
            end
          endcase
        end
      endcase
      laneHit[LANES-1-b] = hit && strobe.access;
      laneData[BYTE_W*(LANES-1-b) +: BYTE_W] = (hit && strobe.write) ? srcByte : '0;
    end
  end

  assign memValid  = strobe.access;
  assign memWrite  = strobe.write;
  assign memAddr   = {reqAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign memByteEn = laneHit;
  assign memWdata  = laneData;

  // Response side: remember what the read needs for merging.
  accSize_e          rspSize;
  accKind_e          rspKind;
  logic              rspSext;
  logic [OFF_W-1:0]  rspOff;
  logic [WORD_W-1:0] rspOld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspSize  <= SZ_BYTE;
      rspKind  <= AK_PLAIN;
      rspSext  <= 1'b0;
      rspOff   <= '0;
      rspOld   <= '0;
    end else begin
      rspValid <= strobe.access && !strobe.write;
      rspSize  <= strobe.size;
      rspKind  <= strobe.kind;
      rspSext  <= strobe.signExt;
      rspOff   <= reqAddr[OFF_W-1:0];
      rspOld   <= reqRegOld;
    end
  end

  always_comb begin
    int offR;
    logic [BYTE_W-1:0]   oneByte;
    logic [2*BYTE_W-1:0] oneHalf;
    offR    = int'(rspOff);
    rspData = '0;
    oneByte = getByte(memRdata, offR);
    oneHalf = {getByte(memRdata, offR), getByte(memRdata, (offR + 1) % LANES)};
    unique case (rspKind)
      AK_LEFT: begin
        for (int r = 0; r < LANES; r++)
          rspData[BYTE_W*(LANES-1-r) +: BYTE_W] =
            (r + offR <= LANES - 1) ? getByte(memRdata, r + offR) : getByte(rspOld, r);
      end
      AK_RIGHT: begin
        for (int r = 0; r < LANES; r++)
          rspData[BYTE_W*(LANES-1-r) +: BYTE_W] =
            (r >= LANES - 1 - offR) ? getByte(memRdata, r - (LANES - 1) + offR)
                                    : getByte(rspOld, r);
      end
      default: begin
        unique case (rspSize)
          SZ_BYTE: rspData = {{(WORD_W-BYTE_W){rspSext & oneByte[BYTE_W-1]}}, oneByte};
          SZ_HALF: rspData = {{(WORD_W-2*BYTE_W){rspSext & oneHalf[2*BYTE_W-1]}}, oneHalf};
          default: rspData = memRdata;
        endcase
      end
    endcase
  end

endmodule

// File: rtl/lsu_merge_unit.sv
module lsu_merge_unit
  import lsu_merge_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [3:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqStoreData,
  input  logic [31:0]       reqRegOld,
  input  logic [31:0]       memRdata,
  output logic              memValid,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [3:0]        memByteEn,
  output logic [31:0]       memWdata,
  output logic              faultValid,
  output logic [ADDR_W-1:0] faultAddr,
  output logic              rspValid,
  output logic [31:0]       rspData
);

  lsuStrobe_t strobe;

  lsu_merge_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .reqValid  (reqValid),
    .reqOp     (reqOp),
    .reqAddr   (reqAddr),
    .strobe    (strobe),
    .faultValid(faultValid),
    .faultAddr (faultAddr)
  );

  lsu_merge_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqAddr     (reqAddr),
    .reqStoreData(reqStoreData),
    .reqRegOld   (reqRegOld),
    .memRdata    (memRdata),
    .memValid    (memValid),
    .memWrite    (memWrite),
    .memAddr     (memAddr),
    .memByteEn   (memByteEn),
    .memWdata    (memWdata),
    .rspValid    (rspValid),
    .rspData     (rspData)
  );

endmodule

// File: rtl/lsu_merge_checker.sv
module lsu_merge_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [3:0]        reqOp,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              memValid,
  input logic              memWrite,
  input logic [ADDR_W-1:0] memAddr,
  input logic [3:0]        memByteEn,
  input logic              faultValid,
  input logic              rspValid
);

  logic neverFaults;
  assign neverFaults = (reqOp == 4'd0) || (reqOp == 4'd1) || (reqOp == 4'd5) ||
                       (reqOp >= 4'd8 && reqOp <= 4'd11);

  a_r1_fault_only_misaligned: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> (reqValid && (reqAddr[0] || reqAddr[1])));

  a_r10_fault_blocks_access: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> !memValid);

  a_r10_no_rsp_after_fault: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |=> !rspValid);

  a_r2_no_fault_byte_unaligned: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && neverFaults) |-> !faultValid);

  a_r3_word_address: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> (memAddr[1:0] == 2'b00));

  a_r4_rsp_after_read: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(memValid && !memWrite));

  a_r7_some_lane: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> (memByteEn != 4'b0000));

  a_r8_left_reaches_last: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && reqOp == 4'd10) |-> memByteEn[0]);

  a_r9_right_reaches_first: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && reqOp == 4'd11) |-> memByteEn[3]);

  a_r11_quiet_idle: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!memValid && !faultValid));

endmodule

bind lsu_merge_unit lsu_merge_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqOp     (reqOp),
  .reqAddr   (reqAddr),
  .memValid  (memValid),
  .memWrite  (memWrite),
  .memAddr   (memAddr),
  .memByteEn (memByteEn),
  .faultValid(faultValid),
  .rspValid  (rspValid)
);

// File: tb/tb_lsu_merge_unit.sv
`timescale 1ns/1ps
module tb_lsu_merge_unit;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [3:0]  reqOp;
  logic [31:0] reqAddr;
  logic [31:0] reqStoreData;
  logic [31:0] reqRegOld;
  logic [31:0] memRdata;
  logic        memValid;
  logic        memWrite;
  logic [31:0] memAddr;
  logic [3:0]  memByteEn;
  logic [31:0] memWdata;
  logic        faultValid;
  logic [31:0] faultAddr;
  logic        rspValid;
  logic [31:0] rspData;

  int checks = 0;
  int failures = 0;

  logic [31:0] mem    [16];
  logic [31:0] shadow [16];

  always #4 clk = ~clk;

  lsu_merge_unit #(.ADDR_W(32)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqStoreData(reqStoreData), .reqRegOld(reqRegOld), .memRdata(memRdata),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr), .memByteEn(memByteEn),
    .memWdata(memWdata), .faultValid(faultValid), .faultAddr(faultAddr),
    .rspValid(rspValid), .rspData(rspData)
  );

  // Simple synchronous word memory.
  always @(posedge clk) begin
    if (memValid) begin
      if (memWrite) begin
        for (int j = 0; j < 4; j++)
          if (memByteEn[j]) mem[memAddr[5:2]][8*j +: 8] <= memWdata[8*j +: 8];
      end else begin
        memRdata <= mem[memAddr[5:2]];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string tagOf(input int op);
    case (op)
      0, 1, 2, 3, 4: return "R4";
      5, 6, 7:       return "R7";
      8:             return "R5";
      9:             return "R6";
      10:            return "R8";
      11:            return "R9";
      default:       return "R10";
    endcase
  endfunction

  function automatic bit isLoad(input int op);
    return (op <= 4) || op == 8 || op == 9;
  endfunction

  function automatic bit isStore(input int op);
    return (op >= 5 && op <= 7) || op == 10 || op == 11;
  endfunction

  function automatic bit expFault(input int op, input int k);
    if (op == 2 || op == 3 || op == 6) return (k % 2) != 0;
    if (op == 4 || op == 7) return k != 0;
    return 1'b0;
  endfunction

  function automatic logic [3:0] expEn(input int op, input int k);
    case (op)
      0, 1, 5:  return 4'b1000 >> k;
      2, 3, 6:  return 4'b1100 >> k;
      8, 10:    return 4'b1111 >> k;
      9, 11:    return 4'((5'b01111 << (3 - k)) & 5'b01111);
      default:  return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] laneMask(input logic [3:0] en);
    logic [31:0] m = '0;
    for (int j = 0; j < 4; j++) if (en[j]) m[8*j +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic logic [31:0] expWdata(input int op, input int k, input logic [31:0] sd);
    logic [31:0] raw;
    case (op)
      5:  raw = (sd & 32'hFF) << (8 * (3 - k));
      6:  raw = (sd & 32'hFFFF) << (8 * (2 - k));
      10: raw = sd >> (8 * k);
      11: raw = sd << (8 * (3 - k));
      default: raw = sd;
    endcase
    return raw & laneMask(expEn(op, k));
  endfunction

  function automatic logic [31:0] expLoad(input int op, input int k,
                                          input logic [31:0] m, input logic [31:0] old);
    logic [31:0] b, h;
    b = (m >> (24 - 8 * k)) & 32'hFF;
    h = (m >> (16 - 8 * k)) & 32'hFFFF;
    case (op)
      0: return (b[7]  ? 32'hFFFFFF00 : 32'h0) | b;
      1: return b;
      2: return (h[15] ? 32'hFFFF0000 : 32'h0) | h;
      3: return h;
      8: return (k == 0) ? m : ((m << (8 * k)) | (old & ((32'd1 << (8 * k)) - 1)));
      9: return (k == 3) ? m : ((m >> (8 * (3 - k))) | (old & ~(32'hFFFFFFFF >> (8 * (3 - k)))));
      default: return m;
    endcase
  endfunction

  // One request; checks the request-cycle outputs and the following response cycle.
  task automatic doReq(input int op, input int w, input int k,
                       input logic [31:0] sd, input logic [31:0] old);
    logic [31:0] a;
    bit f;
    string tg;
    a  = 32'(w * 4 + k);
    f  = expFault(op, k);
    tg = tagOf(op);
    @(negedge clk);
    reqValid = 1'b1; reqOp = 4'(op); reqAddr = a; reqStoreData = sd; reqRegOld = old;
    #1;
    chk(faultValid == f, f ? "R1" : "R2", "faultValid", 32'(faultValid), 32'(f));
    if (f) begin
      chk(faultAddr == a, "R1", "faultAddr", faultAddr, a);
      chk(!memValid, "R10", "memValid on fault", 32'(memValid), 0);
    end else if (op >= 12) begin
      chk(!memValid, "R10", "memValid on unused code", 32'(memValid), 0);
    end else begin
      chk(memValid, tg, "memValid", 32'(memValid), 1);
      chk(memAddr == (a & ~32'd3), "R3", "memAddr", memAddr, a & ~32'd3);
      chk(memWrite == isStore(op), tg, "memWrite", 32'(memWrite), 32'(isStore(op)));
      chk(memByteEn == expEn(op, k), tg, "memByteEn", 32'(memByteEn), 32'(expEn(op, k)));
      if (isStore(op)) begin
        chk(memWdata == expWdata(op, k, sd), tg, "memWdata", memWdata, expWdata(op, k, sd));
        shadow[w] = (shadow[w] & ~laneMask(expEn(op, k))) | expWdata(op, k, sd);
      end
    end
    @(negedge clk);
    reqValid = 1'b0;
    #1;
    if (!f && op < 12 && isLoad(op)) begin
      chk(rspValid, tg, "rspValid", 32'(rspValid), 1);
      chk(rspData == expLoad(op, k, shadow[w], old), tg, "rspData",
          rspData, expLoad(op, k, shadow[w], old));
    end else begin
      chk(!rspValid, "R10", "rspValid without load", 32'(rspValid), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqOp = '0; reqAddr = '0;
    reqStoreData = '0; reqRegOld = '0; memRdata = '0;
    for (int i = 0; i < 16; i++) begin mem[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    chk(!memValid && !faultValid && !rspValid, "R11", "outputs in reset",
        {29'd0, memValid, faultValid, rspValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!memValid && !faultValid && !rspValid, "R11", "outputs after reset",
        {29'd0, memValid, faultValid, rspValid}, 0);

    // Seed four words with sign-bit-rich patterns through aligned word stores.
    for (int w = 0; w < 4; w++)
      doReq(7, w, 0, 32'h8F7E6D5C ^ (32'h11223344 * 32'(w)), 32'h0);

    // Sweep every code over every offset, verifying memory after each access.
    for (int op = 0; op < 13; op++) begin
      for (int w = 0; w < 4; w++) begin
        for (int k = 0; k < 4; k++) begin
          logic [31:0] sd, old;
          sd  = 32'hC3A5_F00F ^ (32'(op) << 20) ^ (32'(k) << 9) ^ 32'(w * 77);
          old = 32'h5A69_7887 ^ (32'(op) << 3) ^ (32'(k) << 26);
          doReq(op, w, k, sd, old);
          if (!isLoad(op)) doReq(4, w, 0, 32'h0, 32'h0);
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule